// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block paces the serial clock of an I2C master. From the peripheral clock it derives an internal tick through a programmable pre-divider. It then counts ticks into SCL periods. Each period has a low half and a high half of roughly equal length. A bit shifter next to it acts on three one-cycle strobes: SCL goes low, SDA may change, SCL goes high. The generator also drives a registered SCL level.

The divider word holds two fields. The low field sets the pre-divider, so the tick rate is the peripheral clock divided by one plus that field. The high field adds eight ticks to the period for each step. A compensation count for rise time, fall time and internal delay is added to a base of twenty ticks. An optional first-bit setup delay holds SCL low in the very first period, so SCL rises a fixed number of ticks after the first SDA change.

The configuration is captured when `run_i` rises and is then held until `run_i` falls. The generator therefore never changes pace in the middle of a transfer.

Top module: `i2c_scl_rategen`

## Requirements
- R1: While reset is asserted, and after it, until `run_i` is first sampled high, `tick_o`, `scl_fall_o`, `sda_chg_o` and `scl_rise_o` are 0 and `scl_o` is 1.
- R2: Count n = 0 from the first cycle after the edge that samples `run_i` high. Then `tick_o` is 1 exactly in the cycles where n mod (C+1) equals C, where C is the captured pre-divider field. There is no tick in the cycle in which `run_i` first reads high.
- R3: `div_cfg_i[2:0]` is the pre-divider field C (0 to 7), and `div_cfg_i[8:3]` is the period step field G (0 to 63).
- R4: Outside the first period, `scl_fall_o` pulses once every P = 20 + 8*G + K ticks, where K is `comp_i` (0 to 255). Period positions count ticks from 0, and the first tick after start is position 0 of the first period, where `scl_fall_o` pulses.
- R5: With L = floor(P/2), `sda_chg_o` pulses at position floor(L/2) and `scl_rise_o` pulses at position L of every period, except that `scl_rise_o` moves under R6.
- R6: When `fbs_en_i` is 1 at start, the first period raises SCL at position floor(L/2)+17. That period then lasts floor(L/2)+17+(P-L) ticks before the next fall.
- R7: When `fbs_en_i` is 0 at start, the first period has the normal length and positions.
- R8: Changes to `div_cfg_i`, `comp_i` and `fbs_en_i` while running have no effect on any output until `run_i` has been low and rises again.
- R9: In the cycle after the edge that samples `run_i` low, no tick or strobe is output. From the cycle after that, `scl_o` is 1.
- R10: `scl_o` is 0 from the cycle after a `scl_fall_o` pulse through the cycle of the next `scl_rise_o` pulse, and it is 1 from the cycle after that rise.
- R11: The three strobes are mutually exclusive, and each occurs only in a cycle with `tick_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Generator runs while high; its rising edge captures the configuration |
| div_cfg_i | input | 9 | Divider word: pre-divider field in [2:0], period step field in [8:3] |
| comp_i | input | 8 | Rise/fall compensation ticks added to each period |
| fbs_en_i | input | 1 | Enables the first-bit setup delay for the first period |
| tick_o | output | 1 | Internal tick enable, one cycle wide |
| scl_fall_o | output | 1 | Strobe: SCL is to be driven low |
| sda_chg_o | output | 1 | Strobe: SDA may change |
| scl_rise_o | output | 1 | Strobe: SCL is to be released high |
| scl_o | output | 1 | Registered SCL level |

## Verification
The hardest case to reach is the first period with the setup delay, because it exists only once per start. The same holds for a configuration change made mid-run that must stay invisible. The stimulus therefore restarts the generator many times with fresh random divider words and compensation counts, and toggles the delay enable between starts. In one directed run it rewrites every configuration input on each cycle while running. Boundary runs cover the largest period with the smallest pre-divider and the largest pre-divider with the shortest period.

// File: rtl/i2c_rategen_pkg.sv
package i2c_rategen_pkg;

  // Strobe bundle passed from the phase counter to the top.
  typedef struct packed {
    logic fall;
    logic sda;
    logic rise;
  } rg_strobe_t;

  // SCL period in ticks: base, plus step ticks per divider step, plus compensation.
  function automatic int unsigned rg_period(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned scgd,
                                            input int unsigned comp);
    return base + step * scgd + comp;
  endfunction

  // Low half of a period; the high half takes the remainder.
  function automatic int unsigned rg_low(input int unsigned per);
    return per / 2;
  endfunction

  // Largest period end any configuration can reach, used to size counters.
  function automatic int unsigned rg_max_end(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned scgd_w,
                                             input int unsigned comp_w,
                                             input int unsigned fbs);
    return base + step * ((32'd1 << scgd_w) - 1) + ((32'd1 << comp_w) - 1) + fbs;
  endfunction

endpackage

// File: rtl/i2c_rategen_shadow.sv
module i2c_rategen_shadow
  import i2c_rategen_pkg::*;
#(
  parameter int CDF_W      = 3,
  parameter int SCGD_W     = 6,
  parameter int COMP_W     = 8,
  parameter int BASE_TICKS = 20,
  parameter int STEP_TICKS = 8,
  parameter int FBS_TICKS  = 17,
  parameter int POS_W      = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_i,
  input  logic [CDF_W+SCGD_W-1:0] div_cfg_i,
  input  logic [COMP_W-1:0]       comp_i,
  input  logic                    fbs_en_i,
  output logic                    running_o,
  output logic [CDF_W-1:0]        cdf_o,
  output logic [POS_W-1:0]        end_norm_m1_o,
  output logic [POS_W-1:0]        rise_norm_o,
  output logic [POS_W-1:0]        sda_pos_o,
  output logic [POS_W-1:0]        end_first_m1_o,
  output logic [POS_W-1:0]        rise_first_o,
  output logic                    fbs_o
);

  localparam int CFG_W = CDF_W + SCGD_W;

  logic              running_q;
  logic              load;
  logic [CDF_W-1:0]  cdf_f;
  logic [SCGD_W-1:0] scgd_f;

  int unsigned per_w;
  int unsigned low_w;
  int unsigned high_w;
  int unsigned sda_w;

  // Field split of the divider word: the pre-divider sits at the bottom.
  assign cdf_f  = div_cfg_i[CDF_W-1:0];
  assign scgd_f = div_cfg_i[CFG_W-1:CDF_W];

  assign load = run_i && !running_q;

  always_comb begin
    per_w  = rg_period(32'(BASE_TICKS), 32'(STEP_TICKS), 32'(scgd_f), 32'(comp_i));
    low_w  = rg_low(per_w);
    high_w = per_w - low_w;
    sda_w  = low_w / 2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
    end else begin
      running_q <= run_i;
    end
  end

  // Timing is captured once per start and held for the whole run.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cdf_o          <= '0;
      end_norm_m1_o  <= '0;
      rise_norm_o    <= '0;
      sda_pos_o      <= '0;
      end_first_m1_o <= '0;
      rise_first_o   <= '0;
      fbs_o          <= 1'b0;
    end else if (load) begin
      cdf_o          <= cdf_f;
      end_norm_m1_o  <= POS_W'(per_w - 1);
      rise_norm_o    <= POS_W'(low_w);
      sda_pos_o      <= POS_W'(sda_w);
      rise_first_o   <= POS_W'(sda_w + 32'(FBS_TICKS));
      end_first_m1_o <= POS_W'(sda_w + 32'(FBS_TICKS) + high_w - 1);
      fbs_o          <= fbs_en_i;
    end
  end

  assign running_o = running_q;

endmodule

// File: rtl/i2c_rategen_prescale.sv
module i2c_rategen_prescale #(
  parameter int CDF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running_i,
  input  logic [CDF_W-1:0] cdf_i,
  output logic             tick_o
);

  logic [CDF_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == cdf_i);
  assign tick_o = running_i && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!running_i) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/i2c_rategen_phase.sv
module i2c_rategen_phase
  import i2c_rategen_pkg::*;
#(
  parameter int POS_W     = 10,
  parameter int FBS_TICKS = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running_i,
  input  logic             tick_i,
  input  logic [POS_W-1:0] end_norm_m1_i,
  input  logic [POS_W-1:0] rise_norm_i,
  input  logic [POS_W-1:0] sda_pos_i,
  input  logic [POS_W-1:0] end_first_m1_i,
  input  logic [POS_W-1:0] rise_first_i,
  input  logic             fbs_i,
  output rg_strobe_t       strobe_o,
  output logic             scl_o
);

  logic [POS_W-1:0] pos_q;
  logic             first_q;
  logic             use_ext;
  logic [POS_W-1:0] end_sel;
  logic [POS_W-1:0] rise_sel;
  logic             at_end;
  logic             scl_q;

  // The first period is stretched only when the delay exists and is enabled.
  generate
    if (FBS_TICKS > 0) begin : g_fbs
      assign use_ext = first_q && fbs_i;
    end else begin : g_nofbs
      logic unused_fbs;
      assign unused_fbs = fbs_i ^ (|end_first_m1_i) ^ (|rise_first_i);
      assign use_ext    = 1'b0;
    end
  endgenerate

  assign end_sel  = use_ext ? end_first_m1_i : end_norm_m1_i;
  assign rise_sel = use_ext ? rise_first_i   : rise_norm_i;
  assign at_end   = (pos_q == end_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      first_q <= 1'b1;
    end else if (!running_i) begin
      pos_q   <= '0;
      first_q <= 1'b1;
    end else if (tick_i) begin
      if (at_end) begin
        pos_q   <= '0;
        first_q <= 1'b0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  always_comb begin
    strobe_o.fall = tick_i && (pos_q == '0);
    strobe_o.sda  = tick_i && (pos_q == sda_pos_i);
    strobe_o.rise = tick_i && (pos_q == rise_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
    end else if (!running_i) begin
      scl_q <= 1'b1;
    end else if (strobe_o.fall) begin
      scl_q <= 1'b0;
    end else if (strobe_o.rise) begin
      scl_q <= 1'b1;
    end
  end

  assign scl_o = scl_q;

endmodule

// File: rtl/i2c_scl_rategen.sv
module i2c_scl_rategen
  import i2c_rategen_pkg::*;
#(
  parameter int CDF_W      = 3,
  parameter int SCGD_W     = 6,
  parameter int COMP_W     = 8,
  parameter int BASE_TICKS = 20,
  parameter int STEP_TICKS = 8,
  parameter int FBS_TICKS  = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_i,
  input  logic [CDF_W+SCGD_W-1:0] div_cfg_i,
  input  logic [COMP_W-1:0]       comp_i,
  input  logic                    fbs_en_i,
  output logic                    tick_o,
  output logic                    scl_fall_o,
  output logic                    sda_chg_o,
  output logic                    scl_rise_o,
  output logic                    scl_o
);

  localparam int MAX_END = int'(rg_max_end(32'(BASE_TICKS), 32'(STEP_TICKS),
                                           32'(SCGD_W), 32'(COMP_W), 32'(FBS_TICKS)));
  localparam int POS_W   = $clog2(MAX_END + 1);

  logic             running;
  logic [CDF_W-1:0] cdf_s;
  logic [POS_W-1:0] end_norm_m1;
  logic [POS_W-1:0] rise_norm;
  logic [POS_W-1:0] sda_pos;
  logic [POS_W-1:0] end_first_m1;
  logic [POS_W-1:0] rise_first;
  logic             fbs_s;
  logic             tick;
  rg_strobe_t       strobe;

  i2c_rategen_shadow #(
    .CDF_W      (CDF_W),
    .SCGD_W     (SCGD_W),
    .COMP_W     (COMP_W),
    .BASE_TICKS (BASE_TICKS),
    .STEP_TICKS (STEP_TICKS),
    .FBS_TICKS  (FBS_TICKS),
    .POS_W      (POS_W)
  ) u_shadow (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_i          (run_i),
    .div_cfg_i      (div_cfg_i),
    .comp_i         (comp_i),
    .fbs_en_i       (fbs_en_i),
    .running_o      (running),
    .cdf_o          (cdf_s),
    .end_norm_m1_o  (end_norm_m1),
    .rise_norm_o    (rise_norm),
    .sda_pos_o      (sda_pos),
    .end_first_m1_o (end_first_m1),
    .rise_first_o   (rise_first),
    .fbs_o          (fbs_s)
  );

  i2c_rategen_prescale #(
    .CDF_W (CDF_W)
  ) u_prescale (
    .clk       (clk),
    .rst_n     (rst_n),
    .running_i (running),
    .cdf_i     (cdf_s),
    .tick_o    (tick)
  );

  i2c_rategen_phase #(
    .POS_W     (POS_W),
    .FBS_TICKS (FBS_TICKS)
  ) u_phase (
    .clk            (clk),
    .rst_n          (rst_n),
    .running_i      (running),
    .tick_i         (tick),
    .end_norm_m1_i  (end_norm_m1),
    .rise_norm_i    (rise_norm),
    .sda_pos_i      (sda_pos),
    .end_first_m1_i (end_first_m1),
    .rise_first_i   (rise_first),
    .fbs_i          (fbs_s),
    .strobe_o       (strobe),
    .scl_o          (scl_o)
  );

  assign tick_o     = tick;
  assign scl_fall_o = strobe.fall;
  assign sda_chg_o  = strobe.sda;
  assign scl_rise_o = strobe.rise;

endmodule

// File: rtl/i2c_scl_rategen_chk.sv
module i2c_scl_rategen_chk (
  input logic clk,
  input logic rst_n,
  input logic run_i,
  input logic tick_o,
  input logic scl_fall_o,
  input logic sda_chg_o,
  input logic scl_rise_o,
  input logic scl_o
);

  p_strobe_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_fall_o, sda_chg_o, scl_rise_o}));

  p_strobe_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall_o || sda_chg_o || scl_rise_o) |-> tick_o);

  p_scl_low_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall_o && run_i) |=> !scl_o);

  p_scl_high_after_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_o |=> scl_o);

  p_quiet_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!tick_o && !scl_fall_o && !sda_chg_o && !scl_rise_o));

  p_no_tick_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> !tick_o);

endmodule

bind i2c_scl_rategen i2c_scl_rategen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_i      (run_i),
  .tick_o     (tick_o),
  .scl_fall_o (scl_fall_o),
  .sda_chg_o  (sda_chg_o),
  .scl_rise_o (scl_rise_o),
  .scl_o      (scl_o)
);

// File: tb/sim_i2c_scl_rategen.sv
module sim_i2c_scl_rategen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_i = 1'b0;
  logic [8:0] div_cfg_i = '0;
  logic [7:0] comp_i = '0;
  logic       fbs_en_i = 1'b0;
  logic       tick_o, scl_fall_o, sda_chg_o, scl_rise_o, scl_o;

  int vecs = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_scl_rategen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .div_cfg_i  (div_cfg_i),
    .comp_i     (comp_i),
    .fbs_en_i   (fbs_en_i),
    .tick_o     (tick_o),
    .scl_fall_o (scl_fall_o),
    .sda_chg_o  (sda_chg_o),
    .scl_rise_o (scl_rise_o),
    .scl_o      (scl_o)
  );

  function automatic int per_of(int g, int k);
    return 20 + 8 * g + k;
  endfunction

  // Expected {tick, fall, sda, rise} in cycle n of a run, from R2, R4, R5, R6.
  function automatic logic [3:0] expect_at(int n, int c, int g, int k, bit fbs);
    int p, l, h, s, e1, t, pos, rise_pos;
    bit in_first;
    p = per_of(g, k);
    l = p / 2;
    h = p - l;
    s = l / 2;
    e1 = fbs ? (s + 17 + h) : p;
    if ((n % (c + 1)) != c) return 4'b0000;
    t = n / (c + 1);
    in_first = (t < e1);
    pos = in_first ? t : ((t - e1) % p);
    rise_pos = (in_first && fbs) ? (s + 17) : l;
    return {1'b1, pos == 0, pos == s, pos == rise_pos};
  endfunction

  task automatic check_idle(string req, bit with_scl);
    logic [4:0] act;
    logic [4:0] exp;
    act = {tick_o, scl_fall_o, sda_chg_o, scl_rise_o, with_scl ? scl_o : 1'b1};
    exp = 5'b00001;
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s idle: actual %b expected %b", req, act, exp);
    end
  endtask

  // One start/stop run; scramble rewrites the configuration every cycle (R8).
  task automatic run_case(int c, int g, int k, bit fbs, bit scramble, string ctx);
    int p, l, h, s, e1, ncyc;
    bit exp_scl;
    p = per_of(g, k);
    l = p / 2;
    h = p - l;
    s = l / 2;
    e1 = fbs ? (s + 17 + h) : p;
    ncyc = (e1 + 2 * p + 3) * (c + 1);
    div_cfg_i = {g[5:0], c[2:0]};   // R3: step field in [8:3], pre-divider in [2:0]
    comp_i    = k[7:0];
    fbs_en_i  = fbs;
    run_i     = 1'b1;
    exp_scl   = 1'b1;
    for (int n = 0; n < ncyc; n++) begin
      logic [3:0] e;
      logic [4:0] act;
      logic [4:0] exp;
      @(negedge clk);
      e = expect_at(n, c, g, k, fbs);
      act = {tick_o, scl_fall_o, sda_chg_o, scl_rise_o, scl_o};
      exp = {e, exp_scl};
      vecs++;
      if (act !== exp) begin
        string req;
        fails++;
        if (act[4] !== exp[4]) req = "R2";
        else if (act[3] !== exp[3]) req = (n / (c + 1) < e1) ? "R6" : "R4";
        else if (act[2] !== exp[2]) req = "R5";
        else if (act[1] !== exp[1]) req = (fbs && (n / (c + 1) < e1)) ? "R6" : "R5";
        else req = "R10";
        // R11 is covered too: expected strobes never overlap.
        $display("FAIL %s [%s] cycle %0d: actual %b expected %b", req, ctx, n, act, exp);
      end
      if (e[2]) exp_scl = 1'b0;
      if (e[0]) exp_scl = 1'b1;
      if (scramble) begin
        div_cfg_i = 9'($urandom);
        comp_i    = 8'($urandom);
        fbs_en_i  = 1'($urandom);
      end
    end
    run_i = 1'b0;
    @(negedge clk);
    check_idle("R9", 1'b0);
    @(negedge clk);
    check_idle("R9", 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1C2B;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check_idle("R1", 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1", 1'b1);
    @(negedge clk);
    check_idle("R1", 1'b1);

    run_case(5, 1, 0, 1'b0, 1'b0, "R3 fields");
    run_case(0, 0, 0, 1'b0, 1'b0, "R7 plain first period");
    run_case(1, 2, 7, 1'b1, 1'b0, "R6 setup delay");
    run_case(0, 63, 255, 1'b1, 1'b0, "R4 longest period");
    run_case(7, 0, 0, 1'b0, 1'b0, "R2 slowest tick");
    run_case(2, 3, 1, 1'b0, 1'b0, "R5 odd period");
    run_case(3, 4, 9, 1'b1, 1'b1, "R8 config held");
    run_case(0, 5, 2, 1'b0, 1'b1, "R8 config held");
    for (int i = 0; i < 22; i++) begin
      run_case(int'($urandom % 8), int'($urandom % 16), int'($urandom % 41),
               1'($urandom), 1'($urandom), "random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule